// File: doc/BRIEF.md
# Per-Lane Integer and Bitwise Execution Unit

This block executes one integer or bit-manipulation operation for a single 32-bit lane per cycle. The issue stage presents an opcode, a modifier, up to three source operands already read from the register file, and the lane's predicate controls. One clock later the block presents either a register result with its write strobe or a one-bit predicate result with its own strobe. Nothing is written when the lane is predicated off, when the issue slot is empty, or when the opcode or modifier is not one the unit implements. In that last case a flag is raised.

Arithmetic wraps modulo 2^32. Minimum and maximum come in separate signed and unsigned forms. Shift distances use only the low five bits of the second operand. Comparisons produce predicates and never register writes. Division, remainder, bitfield extract and insert, floating point and memory access are handled elsewhere.

Top module: `lane_int_alu`

## Requirements
- R1: While rst_ni is low, and afterwards until the first valid issue, valid_o, rd_we_o, pred_we_o, pred_o, illegal_o and result_o are all 0.
- R2: Every output is registered. An issue accepted at a rising edge appears on the outputs after that edge. Opcode 0x00 gives a+b, 0x01 gives a-b and 0x07 gives 0-a, all modulo 2^32.
- R3: Opcode 0x02 gives bits [31:0] of a*b. Opcode 0x03 gives bits [63:32] of the signed 64-bit product of a and b.
- R4: Opcodes 0x09 and 0x0A give the signed minimum and maximum of a and b. Opcodes 0x0C and 0x0D give the unsigned minimum and maximum.
- R5: Opcode 0x0B gives a clamped to the signed range [b, c]. The result is b if a<b, otherwise c if a>c, otherwise a.
- R6: Opcode 0x08 gives the signed absolute value of a. An input of 0x80000000 returns 0x80000000.
- R7: Opcodes 0x20, 0x21, 0x22 and 0x23 give a AND b, a OR b, a XOR b and NOT a.
- R8: Opcode 0x24 shifts a by b[4:0]. Modifier 0 shifts left, modifier 1 shifts right logically and modifier 2 shifts right arithmetically.
- R9: Opcode 0x25 works on a. Modifier 0 gives the count of set bits. Modifier 1 gives the index of the most significant set bit, or 0xFFFFFFFF when a is zero. Modifier 2 gives a with its bit order reversed.
- R10: Opcode 0x28 is a signed compare of a against b, with modifiers 0..5 selecting eq, ne, lt, le, gt and ge. Opcode 0x29 is an unsigned compare, with modifier 0 selecting lt and modifier 1 selecting le. A compare sets pred_we_o and drives the outcome on pred_o, while rd_we_o stays 0 and result_o is 0.
- R11: If pred_en_i is 1 and pred_i equals pred_neg_i, the lane is predicated off. Then rd_we_o and pred_we_o stay 0 and result_o and pred_o are 0. valid_o and illegal_o are unaffected.
- R12: An opcode not listed above, or a modifier above 2 for 0x24 or 0x25, above 5 for 0x28 or above 1 for 0x29, raises illegal_o with valid_o. No write strobe is raised.
- R13: A register-writing operation that is not predicated off raises rd_we_o and leaves pred_we_o at 0. With valid_i low, the next cycle shows valid_o, illegal_o and both strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue slot occupied |
| opcode_i | input | 8 | Operation code |
| modifier_i | input | 4 | Sub-operation select |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| src_c_i | input | 32 | Third operand (clamp upper bound) |
| pred_i | input | 1 | Lane predicate value |
| pred_neg_i | input | 1 | Invert predicate sense |
| pred_en_i | input | 1 | Predication enable |
| valid_o | output | 1 | Result slot occupied |
| result_o | output | 32 | Register result, 0 when not written |
| rd_we_o | output | 1 | Destination register write strobe |
| pred_o | output | 1 | Predicate result of a compare |
| pred_we_o | output | 1 | Predicate write strobe |
| illegal_o | output | 1 | Unimplemented opcode or modifier |

## Verification
The assertions assume that opcode, modifier, operands and predicate controls are meaningful only while valid_i is high. They also assume that one issue maps to exactly one output cycle, so every property reads its inputs through a single $past step. The stimulus changes all inputs together, half a period away from the capturing edge, and it holds valid_i low during reset. Idle issues carry arbitrary operand values, which shows that those values have no effect.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int unsigned OP_W  = 8;
  localparam int unsigned MOD_W = 4;

  localparam logic [OP_W-1:0] OP_ADD   = 8'h00;
  localparam logic [OP_W-1:0] OP_SUB   = 8'h01;
  localparam logic [OP_W-1:0] OP_MULLO = 8'h02;
  localparam logic [OP_W-1:0] OP_MULHI = 8'h03;
  localparam logic [OP_W-1:0] OP_NEG   = 8'h07;
  localparam logic [OP_W-1:0] OP_ABS   = 8'h08;
  localparam logic [OP_W-1:0] OP_SMIN  = 8'h09;
  localparam logic [OP_W-1:0] OP_SMAX  = 8'h0A;
  localparam logic [OP_W-1:0] OP_CLAMP = 8'h0B;
  localparam logic [OP_W-1:0] OP_UMIN  = 8'h0C;
  localparam logic [OP_W-1:0] OP_UMAX  = 8'h0D;
  localparam logic [OP_W-1:0] OP_AND   = 8'h20;
  localparam logic [OP_W-1:0] OP_OR    = 8'h21;
  localparam logic [OP_W-1:0] OP_XOR   = 8'h22;
  localparam logic [OP_W-1:0] OP_NOT   = 8'h23;
  localparam logic [OP_W-1:0] OP_SHIFT = 8'h24;
  localparam logic [OP_W-1:0] OP_BITS  = 8'h25;
  localparam logic [OP_W-1:0] OP_SCMP  = 8'h28;
  localparam logic [OP_W-1:0] OP_UCMP  = 8'h29;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_BITS  = 2'd2,
    UNIT_CMP   = 2'd3
  } unit_e;
endpackage

// File: rtl/lane_alu_decode.sv
module lane_alu_decode
  import lane_alu_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [MOD_W-1:0] modifier_i,
  output unit_e            unit_o,
  output logic             legal_o
);
  always_comb begin
    unit_o  = UNIT_NONE;
    legal_o = 1'b0;
    unique case (opcode_i)
      OP_ADD, OP_SUB, OP_MULLO, OP_MULHI, OP_NEG, OP_ABS,
      OP_SMIN, OP_SMAX, OP_CLAMP, OP_UMIN, OP_UMAX: begin
        unit_o  = UNIT_ARITH;
        legal_o = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        unit_o  = UNIT_BITS;
        legal_o = 1'b1;
      end
      OP_SHIFT, OP_BITS: begin
        unit_o  = UNIT_BITS;
        legal_o = (modifier_i <= MOD_W'(2));
      end
      OP_SCMP: begin
        unit_o  = UNIT_CMP;
        legal_o = (modifier_i <= MOD_W'(5));
      end
      OP_UCMP: begin
        unit_o  = UNIT_CMP;
        legal_o = (modifier_i <= MOD_W'(1));
      end
      default: begin
        unit_o  = UNIT_NONE;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lane_alu_arith.sv
module lane_alu_arith
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic                     a_lt_b_s, a_gt_c_s, a_lt_b_u;

  assign prod     = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));
  assign a_lt_b_s = $signed(a_i) < $signed(b_i);
  assign a_gt_c_s = $signed(a_i) > $signed(c_i);
  assign a_lt_b_u = a_i < b_i;

  always_comb begin
    res_o = '0;
    unique case (opcode_i)
      OP_ADD:   res_o = a_i + b_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_MULLO: res_o = prod[DATA_W-1:0];
      OP_MULHI: res_o = prod[PROD_W-1:DATA_W];
      OP_NEG:   res_o = '0 - a_i;
      OP_ABS:   res_o = a_i[DATA_W-1] ? ('0 - a_i) : a_i;
      OP_SMIN:  res_o = a_lt_b_s ? a_i : b_i;
      OP_SMAX:  res_o = a_lt_b_s ? b_i : a_i;
      OP_UMIN:  res_o = a_lt_b_u ? a_i : b_i;
      OP_UMAX:  res_o = a_lt_b_u ? b_i : a_i;
      OP_CLAMP: res_o = a_lt_b_s ? b_i : (a_gt_c_s ? c_i : a_i);
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_alu_bits.sv
module lane_alu_bits
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [MOD_W-1:0]  modifier_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [SH_W-1:0]   sh_amt;
  logic [CNT_W-1:0]  pop_cnt;
  logic [DATA_W-1:0] msb_idx;
  logic [DATA_W-1:0] rev;

  assign sh_amt = b_i[SH_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign rev[gi] = a_i[DATA_W-1-gi];
    end
  endgenerate

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < DATA_W; i++) pop_cnt = pop_cnt + CNT_W'(a_i[i]);
  end

  // lowest-to-highest scan: last hit is the top set bit
  always_comb begin
    msb_idx = '1;
    for (int i = 0; i < DATA_W; i++) if (a_i[i]) msb_idx = DATA_W'(i);
  end

  always_comb begin
    res_o = '0;
    unique case (opcode_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHIFT: begin
        case (modifier_i)
          4'd0:    res_o = a_i << sh_amt;
          4'd1:    res_o = a_i >> sh_amt;
          4'd2:    res_o = $unsigned($signed(a_i) >>> sh_amt);
          default: res_o = '0;
        endcase
      end
      OP_BITS: begin
        case (modifier_i)
          4'd0:    res_o = DATA_W'(pop_cnt);
          4'd1:    res_o = msb_idx;
          4'd2:    res_o = rev;
          default: res_o = '0;
        endcase
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_alu_cmp.sv
module lane_alu_cmp
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [MOD_W-1:0]  modifier_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              flag_o
);
  logic eq, slt, ult;

  assign eq  = (a_i == b_i);
  assign slt = $signed(a_i) < $signed(b_i);
  assign ult = a_i < b_i;

  always_comb begin
    flag_o = 1'b0;
    if (opcode_i == OP_SCMP) begin
      case (modifier_i)
        4'd0:    flag_o = eq;
        4'd1:    flag_o = !eq;
        4'd2:    flag_o = slt;
        4'd3:    flag_o = slt | eq;
        4'd4:    flag_o = !(slt | eq);
        4'd5:    flag_o = !slt;
        default: flag_o = 1'b0;
      endcase
    end else if (opcode_i == OP_UCMP) begin
      case (modifier_i)
        4'd0:    flag_o = ult;
        4'd1:    flag_o = ult | eq;
        default: flag_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lane_int_alu.sv
module lane_int_alu
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [3:0]        modifier_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] src_c_i,
  input  logic              pred_i,
  input  logic              pred_neg_i,
  input  logic              pred_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              rd_we_o,
  output logic              pred_o,
  output logic              pred_we_o,
  output logic              illegal_o
);
  unit_e             unit;
  logic              legal, lane_on, do_write;
  logic [DATA_W-1:0] arith_res, bits_res, sel_res;
  logic              cmp_flag;

  lane_alu_decode u_dec (
    .opcode_i  (opcode_i),
    .modifier_i(modifier_i),
    .unit_o    (unit),
    .legal_o   (legal)
  );

  lane_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .opcode_i(opcode_i),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .c_i     (src_c_i),
    .res_o   (arith_res)
  );

  lane_alu_bits #(.DATA_W(DATA_W)) u_bits (
    .opcode_i  (opcode_i),
    .modifier_i(modifier_i),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .res_o     (bits_res)
  );

  lane_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .opcode_i  (opcode_i),
    .modifier_i(modifier_i),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .flag_o    (cmp_flag)
  );

  assign lane_on  = !pred_en_i || (pred_i ^ pred_neg_i);
  assign do_write = valid_i && legal && lane_on;

  always_comb begin
    unique case (unit)
      UNIT_ARITH: sel_res = arith_res;
      UNIT_BITS:  sel_res = bits_res;
      default:    sel_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      rd_we_o   <= 1'b0;
      pred_o    <= 1'b0;
      pred_we_o <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && !legal;
      rd_we_o   <= do_write && (unit != UNIT_CMP);
      pred_we_o <= do_write && (unit == UNIT_CMP);
      pred_o    <= do_write && (unit == UNIT_CMP) && cmp_flag;
      result_o  <= (do_write && (unit != UNIT_CMP)) ? sel_res : '0;
    end
  end
endmodule

// File: rtl/lane_int_alu_chk.sv
module lane_int_alu_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opcode_i,
  input logic [3:0]        modifier_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic              pred_i,
  input logic              pred_neg_i,
  input logic              pred_en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              rd_we_o,
  input logic              pred_we_o,
  input logic              illegal_o
);
  assert_one_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_we_o && pred_we_o));

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !rd_we_o && !pred_we_o && !illegal_o);

  assert_illegal_nowrite_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_o && !rd_we_o && !pred_we_o);

  assert_pred_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pred_en_i && (pred_i == pred_neg_i)
    |=> valid_o && !rd_we_o && !pred_we_o && (result_o == '0));

  assert_add_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pred_en_i && opcode_i == 8'h00
    |=> rd_we_o && result_o == $past(src_a_i) + $past(src_b_i));

  assert_cmp_no_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (opcode_i == 8'h28 || opcode_i == 8'h29) |=> !rd_we_o);

  assert_umin_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pred_en_i && opcode_i == 8'h0C
    |=> result_o <= $past(src_a_i) && result_o <= $past(src_b_i));

  assert_shl_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pred_en_i && opcode_i == 8'h24 && modifier_i == 4'd0
    |=> result_o == ($past(src_a_i) << $past(src_b_i[4:0])));
endmodule

bind lane_int_alu lane_int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opcode_i  (opcode_i),
  .modifier_i(modifier_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .pred_i    (pred_i),
  .pred_neg_i(pred_neg_i),
  .pred_en_i (pred_en_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .rd_we_o   (rd_we_o),
  .pred_we_o (pred_we_o),
  .illegal_o (illegal_o)
);

// File: tb/lane_int_alu_tb.sv
module lane_int_alu_tb;
  typedef struct packed {
    logic        vld;
    logic [31:0] res;
    logic        we;
    logic        prd;
    logic        pwe;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  opc = '0;
  logic [3:0]  modf = '0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic        p = 1'b0, pn = 1'b0, pe = 1'b0;
  logic        valid_o, rd_we_o, pred_o, pred_we_o, illegal_o;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  exp_t   exp_q[$];
  string  tag_q[$];

  always #4 clk = ~clk;

  lane_int_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opc), .modifier_i(modf),
    .src_a_i(a), .src_b_i(b), .src_c_i(c), .pred_i(p), .pred_neg_i(pn), .pred_en_i(pe),
    .valid_o(valid_o), .result_o(result_o), .rd_we_o(rd_we_o), .pred_o(pred_o),
    .pred_we_o(pred_we_o), .illegal_o(illegal_o)
  );

  // reference behaviour written from the requirement text
  function automatic exp_t model(logic v, logic [7:0] o, logic [3:0] m,
                                 logic [31:0] x, logic [31:0] y, logic [31:0] z,
                                 logic pv, logic pnv, logic pev);
    exp_t e = '0;
    logic ok = 1'b1, is_cmp = 1'b0, f = 1'b0;
    logic [31:0] r = '0;
    longint sp;
    int hi;
    e.vld = v;
    if (!v) return e;
    sp = longint'($signed(x)) * longint'($signed(y));
    case (o)
      8'h00: r = x + y;
      8'h01: r = x - y;
      8'h02: r = sp[31:0];
      8'h03: r = sp[63:32];
      8'h07: r = -x;
      8'h08: r = ($signed(x) < 0) ? -x : x;
      8'h09: r = ($signed(x) < $signed(y)) ? x : y;
      8'h0A: r = ($signed(x) > $signed(y)) ? x : y;
      8'h0C: r = (x < y) ? x : y;
      8'h0D: r = (x > y) ? x : y;
      8'h0B: r = ($signed(x) < $signed(y)) ? y : (($signed(x) > $signed(z)) ? z : x);
      8'h20: r = x & y;
      8'h21: r = x | y;
      8'h22: r = x ^ y;
      8'h23: r = ~x;
      8'h24: if (m == 0) r = x << y[4:0];
             else if (m == 1) r = x >> y[4:0];
             else if (m == 2) r = $signed(x) >>> y[4:0];
             else ok = 1'b0;
      8'h25: if (m == 0) r = $countones(x);
             else if (m == 1) begin
               hi = -1;
               for (int k = 31; k >= 0; k--) if (x[k] && hi < 0) hi = k;
               r = 32'(hi);
             end else if (m == 2) begin
               for (int k = 0; k < 32; k++) r[k] = x[31-k];
             end else ok = 1'b0;
      8'h28: begin
        is_cmp = 1'b1;
        case (m)
          0: f = x == y;
          1: f = x != y;
          2: f = $signed(x) < $signed(y);
          3: f = $signed(x) <= $signed(y);
          4: f = $signed(x) > $signed(y);
          5: f = $signed(x) >= $signed(y);
          default: ok = 1'b0;
        endcase
      end
      8'h29: begin
        is_cmp = 1'b1;
        if (m == 0) f = x < y;
        else if (m == 1) f = x <= y;
        else ok = 1'b0;
      end
      default: ok = 1'b0;
    endcase
    e.ill = !ok;
    if (ok && (!pev || (pv != pnv))) begin
      if (is_cmp) begin e.pwe = 1'b1; e.prd = f; end
      else begin e.we = 1'b1; e.res = r; end
    end
    return e;
  endfunction

  task automatic issue(string tag, logic v, logic [7:0] o, logic [3:0] m,
                       logic [31:0] x, logic [31:0] y, logic [31:0] z = '0,
                       logic pev = 1'b0, logic pv = 1'b0, logic pnv = 1'b0);
    @(negedge clk);
    valid = v; opc = o; modf = m; a = x; b = y; c = z; pe = pev; p = pv; pn = pnv;
    exp_q.push_back(model(v, o, m, x, y, z, pv, pnv, pev));
    tag_q.push_back(tag);
  endtask

  task automatic chk(string tag, exp_t act, exp_t exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act vld=%0b res=%h we=%0b prd=%0b pwe=%0b ill=%0b exp vld=%0b res=%h we=%0b prd=%0b pwe=%0b ill=%0b",
               tag, act.vld, act.res, act.we, act.prd, act.pwe, act.ill,
               exp.vld, exp.res, exp.we, exp.prd, exp.pwe, exp.ill);
    end
  endtask

  // monitor: one expected item per issued cycle, sampled 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t act;
        act = '{valid_o, result_o, rd_we_o, pred_o, pred_we_o, illegal_o};
        chk(tag_q.pop_front(), act, exp_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    #3;
    chk("R1 in reset", '{valid_o, result_o, rd_we_o, pred_o, pred_we_o, illegal_o}, '0);
    #20 rst_n = 1'b1;
    #10;
    chk("R1 after reset", '{valid_o, result_o, rd_we_o, pred_o, pred_we_o, illegal_o}, '0);

    issue("R2 add wrap", 1, 8'h00, 0, 32'hFFFF_FFFF, 32'h2);
    issue("R2 sub wrap", 1, 8'h01, 0, 32'h0, 32'h1);
    issue("R2 neg min", 1, 8'h07, 0, 32'h8000_0000, 32'h0);
    issue("R3 mullo", 1, 8'h02, 0, 32'h0001_0000, 32'h0001_0000);
    issue("R3 mulhi", 1, 8'h03, 0, 32'h0001_0000, 32'h0001_0000);
    issue("R3 mulhi neg", 1, 8'h03, 0, 32'hFFFF_FFFE, 32'h3);
    issue("R3 mulhi m1m1", 1, 8'h03, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue("R6 abs min", 1, 8'h08, 0, 32'h8000_0000, 32'h0);
    issue("R6 abs neg", 1, 8'h08, 0, 32'hFFFF_FFFB, 32'h0);
    issue("R4 smin", 1, 8'h09, 0, 32'hFFFF_FFFF, 32'h1);
    issue("R4 smax", 1, 8'h0A, 0, 32'hFFFF_FFFF, 32'h1);
    issue("R4 umin", 1, 8'h0C, 0, 32'hFFFF_FFFF, 32'h1);
    issue("R4 umax", 1, 8'h0D, 0, 32'hFFFF_FFFF, 32'h1);
    issue("R5 clamp low", 1, 8'h0B, 0, 32'hFFFF_FFF0, 32'hFFFF_FFF8, 32'h10);
    issue("R5 clamp high", 1, 8'h0B, 0, 32'h20, 32'hFFFF_FFF8, 32'h10);
    issue("R5 clamp mid", 1, 8'h0B, 0, 32'h5, 32'hFFFF_FFF8, 32'h10);
    issue("R7 and", 1, 8'h20, 0, 32'hF0F0_1234, 32'h0FF0_FFFF);
    issue("R7 or", 1, 8'h21, 0, 32'hF0F0_0000, 32'h0F0F_0001);
    issue("R7 xor", 1, 8'h22, 0, 32'hAAAA_5555, 32'hFFFF_0000);
    issue("R7 not", 1, 8'h23, 0, 32'h0000_FFFF, 32'h0);
    issue("R8 shl masked", 1, 8'h24, 0, 32'h1, 32'h21);
    issue("R8 shr", 1, 8'h24, 1, 32'h8000_0000, 32'h1F);
    issue("R8 sar", 1, 8'h24, 2, 32'h8000_0000, 32'h24);
    issue("R9 popcount", 1, 8'h25, 0, 32'hF00F_0001, 32'h0);
    issue("R9 find zero", 1, 8'h25, 1, 32'h0, 32'h0);
    issue("R9 find", 1, 8'h25, 1, 32'h0001_0003, 32'h0);
    issue("R9 reverse", 1, 8'h25, 2, 32'h0000_0001, 32'h0);
    for (int m = 0; m < 6; m++) begin
      issue("R10 scmp lt", 1, 8'h28, 4'(m), 32'hFFFF_FFFF, 32'h1);
      issue("R10 scmp eq", 1, 8'h28, 4'(m), 32'h7, 32'h7);
    end
    for (int m = 0; m < 2; m++) begin
      issue("R10 ucmp", 1, 8'h29, 4'(m), 32'hFFFF_FFFF, 32'h1);
      issue("R10 ucmp eq", 1, 8'h29, 4'(m), 32'h9, 32'h9);
    end
    issue("R11 off p0", 1, 8'h00, 0, 32'h5, 32'h6, 0, 1, 0, 0);
    issue("R11 off neg", 1, 8'h00, 0, 32'h5, 32'h6, 0, 1, 1, 1);
    issue("R11 on neg", 1, 8'h00, 0, 32'h5, 32'h6, 0, 1, 0, 1);
    issue("R11 on", 1, 8'h01, 0, 32'h5, 32'h6, 0, 1, 1, 0);
    issue("R11 cmp off", 1, 8'h28, 0, 32'h5, 32'h5, 0, 1, 0, 0);
    issue("R12 div", 1, 8'h05, 0, 32'h5, 32'h1);
    issue("R12 shift mod3", 1, 8'h24, 3, 32'h5, 32'h1);
    issue("R12 bits mod3", 1, 8'h25, 3, 32'h5, 32'h1);
    issue("R12 scmp mod6", 1, 8'h28, 6, 32'h5, 32'h1);
    issue("R12 ucmp mod2", 1, 8'h29, 2, 32'h5, 32'h1);
    issue("R12 ff", 1, 8'hFF, 0, 32'h5, 32'h1);
    issue("R12 pred off", 1, 8'h0E, 0, 32'h5, 32'h1, 0, 1, 0, 0);
    issue("R13 idle", 0, 8'h00, 0, 32'hDEAD_BEEF, 32'h1);
    issue("R13 idle bad op", 0, 8'hFF, 0, 32'h1, 32'h1);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] ops [20] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h09, 8'h0A,
                               8'h0B, 8'h0C, 8'h0D, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24,
                               8'h25, 8'h28, 8'h29, 8'h10};
      logic [31:0] x, y, z;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; y = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; z = lfsr;
      issue("R13 mixed", lfsr[7:0] != 8'h00, ops[i % 20], 4'(x[2:0]), x, y, z,
            y[0], z[1], z[2]);
    end

    issue("R13 drain", 0, 8'h00, 0, 32'h0, 32'h0);
    while (exp_q.size() > 0) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule